// File: doc/BRIEF.md
# Serial Shift Register and Latch Decoder for a Multi-Channel PWM LED Driver

This block is the serial front end of a constant-current LED driver. A 769-bit shift register takes one bit per shift event from a serial data pin. On each rising edge of a latch strobe it inspects the word it holds and moves the word into one of two storage latches. The most significant bit picks the target. A zero sends the lower 768 bits to the grayscale latch. A one, together with an 8-bit header key just below it, sends the lower 371 bits to the control latch. A one followed by any other header value updates no latch. The most significant bit of the shift register always drives the serial output, so several devices can be daisy-chained. A separate parallel load port lets the status logic place a fault word into the shift register so that it can be shifted out.

The control latch holds three kinds of setting. The first is a 7-bit dot-correction value for each channel. The second is a 3-bit maximum-current code for each colour group; it only takes effect after the same value has been written twice in a row. The third is a 7-bit brightness code for each colour group plus five mode bits. Brightness and mode bits reach the outputs as soon as the control latch loads. Dot-correction values move into their working latch together with grayscale data. With the refresh mode bit clear, that move happens at the grayscale latch edge itself. With the bit set, both copies wait for an end-of-period strobe from the display counter, and further latch edges are ignored while they wait.

The whole block runs on one system clock. The shift and strobe pins reach it as synchronous signals: `shift_en` marks one serial clock event, and `lat` is a level whose rising edge is detected inside the block.

Top module: `led_serial_latch`

## Requirements
- R1: After reset the shift register, all latches and every output are zero. In a cycle with `shift_en` high and `sid_load` low, `sin` enters bit 0 and every bit moves one place toward bit 768. `sout` always equals bit 768.
- R2: In a cycle with `sid_load` high, all 769 bits of `sid_data` are loaded into the shift register in parallel. This load overrides a shift requested in the same cycle.
- R3: A `lat` rising edge while bit 768 is 0 and the refresh bit is 0 copies shift-register bits 767:0 to `gs_out`. Channel k owns `gs_out[16k+15:16k]`, and channels run red 0, green 0, blue 0, red 1, and so on.
- R4: A `lat` rising edge while bit 768 is 1 and bits 767:760 equal 8'h96 loads shift-register bits 370:0 into the control latch. In the next cycle, `bc_out` shows bits 365:345 (red in bits 6:0, then green, then blue) and `fc_out` shows bits 370:366. The same edge leaves `gs_out` and `dc_out` unchanged.
- R5: `mc_out` holds control bits 344:336 (red in bits 2:0). It changes only on a control write whose field equals the field of the previous control write. A single differing write leaves it unchanged.
- R6: With the refresh bit (`fc_out[2]`, control bit 368) at 0, the grayscale latch edge also copies control bits 335:0 to `dc_out`. Channel k owns bits 7k+6:7k.
- R7: With the refresh bit at 1, a grayscale latch edge changes neither `gs_out` nor `dc_out`. Instead, in the cycle in which `period_end` is sampled high, the shift register's bits 767:0 are copied to `gs_out` and control bits 335:0 are copied to `dc_out`.
- R8: A `lat` rising edge while bit 768 is 1 and the header is not 8'h96 changes no output and does not count as a control write for the R5 pairing.
- R9: While a deferred copy is pending, every `lat` rising edge is ignored. This includes an edge in the same cycle as the `period_end` that ends the wait. A `period_end` with no copy pending changes nothing.
- R10: A latch edge decodes the shift-register contents from before any shift or parallel load in the same cycle, and a `lat` held high acts only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | One serial shift event this cycle |
| sin | input | 1 | Serial data into bit 0 |
| sid_load | input | 1 | Parallel load of the status word |
| sid_data | input | 769 | Status word for the parallel load |
| lat | input | 1 | Latch strobe level; the rising edge acts |
| period_end | input | 1 | End-of-display-period strobe |
| sout | output | 1 | Serial data out (bit 768) |
| gs_out | output | 768 | Grayscale latch, 16 bits per channel |
| dc_out | output | 336 | Working dot-correction latch, 7 bits per channel |
| mc_out | output | 9 | Committed maximum-current codes, 3 per colour |
| bc_out | output | 21 | Brightness codes, 7 per colour |
| fc_out | output | 5 | Mode bits: repeat, timing reset, refresh, enhanced PWM, short threshold |

## Verification
The case that needs care is a deferred copy coinciding with a new strobe. With refresh enabled, a grayscale write is left pending. The bench then raises `lat` and `period_end` in the same cycle. It checks that the copy completes from the current shift-register contents, and that the coincident edge did not start a new pending copy: a later `period_end` with different shift-register contents must leave `gs_out` alone. A second collision is also driven: a latch edge issued together with a shift and with a parallel load. For that one, the bench checks that the word latched is the one held before the shift.

// File: rtl/led_sr_pkg.sv
package led_sr_pkg;

    localparam int N_COLORS   = 3;
    localparam int HDR_W      = 8;
    localparam int FC_W       = 5;
    localparam int FC_REPEAT  = 0;
    localparam int FC_TMGRST  = 1;
    localparam int FC_REFRESH = 2;
    localparam int FC_ESPWM   = 3;
    localparam int FC_SHORTV  = 4;

    typedef enum logic [1:0] {
        LAT_GS   = 2'd0,
        LAT_CTRL = 2'd1,
        LAT_BAD  = 2'd2
    } lat_kind_e;

    function automatic lat_kind_e classify(input logic msb,
                                           input logic [HDR_W-1:0] hdr,
                                           input logic [HDR_W-1:0] key);
        if (!msb)
            return LAT_GS;
        else if (hdr == key)
            return LAT_CTRL;
        else
            return LAT_BAD;
    endfunction

endpackage

// File: rtl/sr_shifter.sv
module sr_shifter #(
    parameter int W = 769
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         sin,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] q
);
    logic [W-1:0] shifted;

    assign shifted = {q[W-2:0], sin};

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= load_data;
        else if (shift_en)
            q <= shifted;
    end
endmodule

// File: rtl/lat_decoder.sv
module lat_decoder
    import led_sr_pkg::*;
#(
    parameter logic [HDR_W-1:0] KEY = 8'h96
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lat,
    input  logic             msb,
    input  logic [HDR_W-1:0] hdr,
    input  logic             refresh,
    input  logic             period_end,
    output logic             lat_rise,
    output logic             gs_commit,
    output logic             ctrl_wr,
    output logic             pending
);
    logic      lat_q;
    logic      accept;
    lat_kind_e kind;

    assign kind      = classify(msb, hdr, KEY);
    assign lat_rise  = lat & ~lat_q;
    assign accept    = lat_rise & ~pending;
    assign gs_commit = (pending & period_end) |
                       (accept & (kind == LAT_GS) & ~refresh);
    assign ctrl_wr   = accept & (kind == LAT_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q   <= 1'b0;
            pending <= 1'b0;
        end else begin
            lat_q <= lat;
            if (pending) begin
                if (period_end)
                    pending <= 1'b0;
            end else if (accept && kind == LAT_GS && refresh) begin
                pending <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mc_commit.sv
module mc_commit #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctrl_wr,
    input  logic [W-1:0] new_code,
    input  logic [W-1:0] prev_code,
    output logic [W-1:0] code
);
    always_ff @(posedge clk) begin
        if (rst)
            code <= '0;
        else if (ctrl_wr && new_code == prev_code)
            code <= new_code;
    end
endmodule

// File: rtl/led_serial_latch.sv
module led_serial_latch
    import led_sr_pkg::*;
#(
    parameter int              N_CH  = 48,
    parameter int              GS_W  = 16,
    parameter int              DC_W  = 7,
    parameter int              MC_W  = 3,
    parameter int              BC_W  = 7,
    parameter logic [HDR_W-1:0] KEY  = 8'h96,
    localparam int GS_BITS = N_CH * GS_W,
    localparam int SR_W    = GS_BITS + 1,
    localparam int DC_BITS = N_CH * DC_W,
    localparam int MC_BITS = N_COLORS * MC_W,
    localparam int BC_BITS = N_COLORS * BC_W,
    localparam int CTRL_W  = DC_BITS + MC_BITS + BC_BITS + FC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               sin,
    input  logic               sid_load,
    input  logic [SR_W-1:0]    sid_data,
    input  logic               lat,
    input  logic               period_end,
    output logic               sout,
    output logic [GS_BITS-1:0] gs_out,
    output logic [DC_BITS-1:0] dc_out,
    output logic [MC_BITS-1:0] mc_out,
    output logic [BC_BITS-1:0] bc_out,
    output logic [FC_W-1:0]    fc_out
);
    localparam int MC_LSB = DC_BITS;
    localparam int BC_LSB = MC_LSB + MC_BITS;
    localparam int FC_LSB = BC_LSB + BC_BITS;

    logic [SR_W-1:0]    sr_q;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [GS_BITS-1:0] gs_q;
    logic [DC_BITS-1:0] dc_q;
    logic               lat_rise;
    logic               gs_commit;
    logic               ctrl_wr;
    logic               pending;

    sr_shifter #(.W(SR_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .sin       (sin),
        .load      (sid_load),
        .load_data (sid_data),
        .q         (sr_q)
    );

    lat_decoder #(.KEY(KEY)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .lat        (lat),
        .msb        (sr_q[SR_W-1]),
        .hdr        (sr_q[SR_W-2 -: HDR_W]),
        .refresh    (ctrl_q[FC_LSB + FC_REFRESH]),
        .period_end (period_end),
        .lat_rise   (lat_rise),
        .gs_commit  (gs_commit),
        .ctrl_wr    (ctrl_wr),
        .pending    (pending)
    );

    // The previous write's code sits in the control latch, so no separate candidate store.
    mc_commit #(.W(MC_BITS)) u_mc (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .new_code  (sr_q[MC_LSB +: MC_BITS]),
        .prev_code (ctrl_q[MC_LSB +: MC_BITS]),
        .code      (mc_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            gs_q   <= '0;
            dc_q   <= '0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= sr_q[CTRL_W-1:0];
            if (gs_commit) begin
                gs_q <= sr_q[GS_BITS-1:0];
                dc_q <= ctrl_q[DC_BITS-1:0];
            end
        end
    end

    assign sout   = sr_q[SR_W-1];
    assign gs_out = gs_q;
    assign dc_out = dc_q;
    assign bc_out = ctrl_q[BC_LSB +: BC_BITS];
    assign fc_out = ctrl_q[FC_LSB +: FC_W];
endmodule

// File: rtl/led_serial_latch_chk.sv
module led_serial_latch_chk #(
    parameter int              SR_W    = 769,
    parameter int              GS_BITS = 768,
    parameter int              DC_BITS = 336,
    parameter int              MC_BITS = 9,
    parameter int              BC_BITS = 21,
    parameter int              FC_W    = 5,
    parameter logic [7:0]      KEY     = 8'h96
) (
    input logic               clk,
    input logic               rst,
    input logic               shift_en,
    input logic               sid_load,
    input logic [SR_W-1:0]    sid_data,
    input logic               period_end,
    input logic               lat_rise,
    input logic               pending,
    input logic               gs_commit,
    input logic               ctrl_wr,
    input logic [SR_W-1:0]    sr_q,
    input logic               sout,
    input logic [GS_BITS-1:0] gs_out,
    input logic [DC_BITS-1:0] dc_out,
    input logic [MC_BITS-1:0] mc_out,
    input logic [BC_BITS-1:0] bc_out,
    input logic [FC_W-1:0]    fc_out
);
    p_shift_r1: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !sid_load) |=> (sout == $past(sr_q[SR_W-2])));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        sid_load |=> (sr_q == $past(sid_data)));

    p_ctrl_only_r4: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> ($stable(bc_out) && $stable(fc_out)));

    p_mc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(mc_out));

    p_dc_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !gs_commit |=> $stable(dc_out));

    p_defer_r7: assert property (@(posedge clk) disable iff (rst)
        (lat_rise && !pending && !sr_q[SR_W-1] && fc_out[2])
        |=> ($stable(gs_out) && $stable(dc_out) && pending));

    p_bad_key_r8: assert property (@(posedge clk) disable iff (rst)
        (lat_rise && !pending && sr_q[SR_W-1] && sr_q[SR_W-2 -: 8] != KEY)
        |=> ($stable(gs_out) && $stable(bc_out) && $stable(fc_out) && $stable(mc_out)));

    p_pending_r9: assert property (@(posedge clk) disable iff (rst)
        (pending && !period_end)
        |=> ($stable(gs_out) && $stable(bc_out) && $stable(fc_out) && pending));
endmodule

bind led_serial_latch led_serial_latch_chk #(
    .SR_W    (SR_W),
    .GS_BITS (GS_BITS),
    .DC_BITS (DC_BITS),
    .MC_BITS (MC_BITS),
    .BC_BITS (BC_BITS),
    .FC_W    (led_sr_pkg::FC_W),
    .KEY     (KEY)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (shift_en),
    .sid_load   (sid_load),
    .sid_data   (sid_data),
    .period_end (period_end),
    .lat_rise   (lat_rise),
    .pending    (pending),
    .gs_commit  (gs_commit),
    .ctrl_wr    (ctrl_wr),
    .sr_q       (sr_q),
    .sout       (sout),
    .gs_out     (gs_out),
    .dc_out     (dc_out),
    .mc_out     (mc_out),
    .bc_out     (bc_out),
    .fc_out     (fc_out)
);

// File: tb/led_serial_latch_bench.sv
module led_serial_latch_bench;
    localparam int N_CH    = 48;
    localparam int GS_BITS = N_CH * 16;
    localparam int SR_W    = GS_BITS + 1;
    localparam int DC_BITS = N_CH * 7;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               shift_en = 1'b0;
    logic               sin = 1'b0;
    logic               sid_load = 1'b0;
    logic [SR_W-1:0]    sid_data = '0;
    logic               lat = 1'b0;
    logic               period_end = 1'b0;
    logic               sout;
    logic [GS_BITS-1:0] gs_out;
    logic [DC_BITS-1:0] dc_out;
    logic [8:0]         mc_out;
    logic [20:0]        bc_out;
    logic [4:0]         fc_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [GS_BITS-1:0] exp_gs = '0;
    logic [DC_BITS-1:0] exp_dc = '0;
    logic [8:0]         exp_mc = '0;
    logic [20:0]        exp_bc = '0;
    logic [4:0]         exp_fc = '0;

    always #5 clk = ~clk;

    led_serial_latch u_led_serial_latch (
        .clk(clk), .rst(rst), .shift_en(shift_en), .sin(sin),
        .sid_load(sid_load), .sid_data(sid_data), .lat(lat),
        .period_end(period_end), .sout(sout), .gs_out(gs_out),
        .dc_out(dc_out), .mc_out(mc_out), .bc_out(bc_out), .fc_out(fc_out)
    );

    function automatic logic [SR_W-1:0] gs_word(input int seed);
        logic [SR_W-1:0] w = '0;
        for (int k = 0; k < N_CH; k++) w[16*k +: 16] = 16'(seed * 4099 + k * 257 + 1);
        return w;
    endfunction

    function automatic logic [DC_BITS-1:0] dc_of(input int seed);
        logic [DC_BITS-1:0] d = '0;
        for (int k = 0; k < N_CH; k++) d[7*k +: 7] = 7'(seed + k * 5);
        return d;
    endfunction

    function automatic logic [SR_W-1:0] ctrl_word(input int seed, input logic [8:0] mc,
                                                  input logic [20:0] bc, input logic [4:0] fc,
                                                  input logic [7:0] key);
        logic [SR_W-1:0] w = '0;
        w[SR_W-1]           = 1'b1;
        w[SR_W-2 -: 8]      = key;
        w[DC_BITS-1:0]      = dc_of(seed);
        w[344:336]          = mc;
        w[365:345]          = bc;
        w[370:366]          = fc;
        return w;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [SR_W-1:0] act, input logic [SR_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "gs_out", SR_W'(gs_out), SR_W'(exp_gs));
        check(req, "dc_out", SR_W'(dc_out), SR_W'(exp_dc));
        check(req, "mc_out", SR_W'(mc_out), SR_W'(exp_mc));
        check(req, "bc_out", SR_W'(bc_out), SR_W'(exp_bc));
        check(req, "fc_out", SR_W'(fc_out), SR_W'(exp_fc));
    endtask

    task automatic shift_in(input logic [SR_W-1:0] w);
        for (int i = SR_W - 1; i >= 0; i--) begin
            @(negedge clk);
            shift_en = 1'b1;
            sin      = w[i];
        end
        @(negedge clk);
        shift_en = 1'b0;
        sin      = 1'b0;
    endtask

    task automatic sid_put(input logic [SR_W-1:0] w);
        @(negedge clk);
        sid_load = 1'b1;
        sid_data = w;
        @(negedge clk);
        sid_load = 1'b0;
    endtask

    task automatic pulse_lat(input logic with_end);
        @(negedge clk);
        lat        = 1'b1;
        period_end = with_end;
        @(negedge clk);
        period_end = 1'b0;
        @(negedge clk);
        lat = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "sout after reset", SR_W'(sout), '0);
        check_all("R1");
    endtask

    task automatic t_gs_write;
        logic [SR_W-1:0] w = gs_word(1);
        shift_in(w);
        check("R1", "sout after shift", SR_W'(sout), SR_W'(w[SR_W-1]));
        pulse_lat(1'b0);
        exp_gs = w[GS_BITS-1:0];
        check_all("R3");
        check("R3", "channel 4 field", SR_W'(gs_out[79:64]), SR_W'(16'(4099 + 4 * 257 + 1)));
    endtask

    task automatic t_sout_stream;
        logic [SR_W-1:0] w = ctrl_word(2, 9'h0, 21'h0, 5'h0, 8'h96);
        shift_in(w);
        for (int i = 0; i < 9; i++) begin
            check("R1", "sout stream", SR_W'(sout), SR_W'(w[SR_W-1-i]));
            @(negedge clk); shift_en = 1'b1; sin = 1'b0;
            @(negedge clk); shift_en = 1'b0;
        end
    endtask

    task automatic t_ctrl_pairs;
        logic [20:0] bc1 = 21'h0A_5C3;
        shift_in(ctrl_word(3, 9'h1A5, bc1, 5'b01001, 8'h96));
        pulse_lat(1'b0);
        exp_bc = bc1; exp_fc = 5'b01001;
        check_all("R4");
        shift_in(ctrl_word(3, 9'h1A5, bc1, 5'b01001, 8'h96));
        pulse_lat(1'b0);
        exp_mc = 9'h1A5;
        check_all("R5");
        shift_in(ctrl_word(5, 9'h0F0, bc1, 5'b01001, 8'h96));
        pulse_lat(1'b0);
        check("R5", "mc after single write", SR_W'(mc_out), SR_W'(exp_mc));
        shift_in(ctrl_word(7, 9'h033, 21'h1F_0F1, 5'b10000, 8'h96));
        pulse_lat(1'b0);
        exp_bc = 21'h1F_0F1; exp_fc = 5'b10000;
        check_all("R5");
        shift_in(ctrl_word(7, 9'h033, 21'h1F_0F1, 5'b10000, 8'h96));
        pulse_lat(1'b0);
        exp_mc = 9'h033;
        check_all("R5");
    endtask

    task automatic t_dc_follow;
        logic [SR_W-1:0] w = gs_word(2);
        shift_in(w);
        pulse_lat(1'b0);
        exp_gs = w[GS_BITS-1:0];
        exp_dc = dc_of(7);
        check_all("R6");
    endtask

    task automatic t_bad_key;
        shift_in(ctrl_word(9, 9'h111, 21'h12_345, 5'b00111, 8'h95));
        pulse_lat(1'b0);
        check_all("R8");
    endtask

    task automatic t_sid_and_collide;
        logic [SR_W-1:0] w = gs_word(3);
        @(negedge clk);
        sid_load = 1'b1; sid_data = w; shift_en = 1'b1; sin = 1'b1;
        @(negedge clk);
        sid_load = 1'b0; shift_en = 1'b0; sin = 1'b0;
        check("R2", "sout after parallel load", SR_W'(sout), SR_W'(w[SR_W-1]));
        @(negedge clk);
        lat = 1'b1; shift_en = 1'b1; sin = 1'b1;
        @(negedge clk);
        shift_en = 1'b0; sin = 1'b0;
        exp_gs = w[GS_BITS-1:0];
        check_all("R10");
        @(negedge clk);
        @(negedge clk);
        lat = 1'b0;
        check("R10", "held lat acts once", SR_W'(gs_out), SR_W'(exp_gs));
        @(negedge clk);
    endtask

    task automatic t_refresh;
        logic [SR_W-1:0] w4 = gs_word(4);
        logic [SR_W-1:0] w5 = gs_word(5);
        shift_in(ctrl_word(11, 9'h033, 21'h03_210, 5'b00100, 8'h96));
        pulse_lat(1'b0);
        exp_bc = 21'h03_210; exp_fc = 5'b00100;
        check_all("R4");
        shift_in(w4);
        pulse_lat(1'b0);
        check_all("R7");
        sid_put(ctrl_word(12, 9'h033, 21'h1F_FFF, 5'b00000, 8'h96));
        pulse_lat(1'b0);
        check_all("R9");
        sid_put(w4);
        pulse_lat(1'b1);
        exp_gs = w4[GS_BITS-1:0];
        exp_dc = dc_of(11);
        check_all("R7");
        sid_put(w5);
        @(negedge clk); period_end = 1'b1;
        @(negedge clk); period_end = 1'b0;
        check_all("R9");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_gs_write();
        t_sout_stream();
        t_ctrl_pairs();
        t_dc_follow();
        t_bad_key();
        t_sid_and_collide();
        t_refresh();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule